// File: doc/BRIEF.md
# Optical Tile Route and Wavelength Selector

This block is the route-computation and transmit-channel selection stage of one tile in a square grid of tiles (4 x 4 by default). Tiles in the same row share one optical row channel, and tiles in the same column share one optical column channel. Inside each shared channel, every receiving tile owns a home channel. A sender at position `p` along that row or column modulates its own band of wavelengths, `LAMBDA_PER` wide and starting at wavelength `p * LAMBDA_PER`.

For each accepted request the block makes three choices:
- the output dimension: the row channel, the column channel, or local ejection;
- the mask of destination home channels to drive;
- the wavelength group, and from it the first wavelength index, that the transmitter uses.

Routing is dimension-ordered. The column is corrected first, over the row channel. The row is corrected next, over the column channel.

A broadcast is not sent as many unicasts. It is issued as a sequence of three multicast beats. The first beat is a row multicast. The second is a column multicast. The third is a row multicast marked as a relay, which tells every tile in the row to repeat the data down its own column.

Requests enter on a valid/ready stream and decisions leave on a valid/ready stream. The output register holds one decision. Rules for back-pressure:
- While `out_valid` is high and `out_ready` is low, every output field stays frozen.
- `req_ready` is high when the output register is empty, or when its last beat is being taken in the same cycle. This gives full throughput.
- A request is captured together with `self_id`.

Top module: `otrs_tile_route`

## Requirements
- R1: A synchronous active-high `rst` leaves the block idle after the edge: `out_valid` 0, `bcast_done` 0 and `req_ready` 1.
- R2: A unicast (kind code 0) whose destination column differs from the own column drives the row channel. `out_dim` is 3'b001 (bit 0 = row, bit 1 = column, bit 2 = local), `out_mask` has only bit `dst_x` set, and `out_wgrp` equals `self_x`. A tile index `t` splits into `x = t mod 4` (low 2 bits) and `y = t div 4` (high 2 bits).
- R3: A unicast in the own column but a different row drives the column channel. `out_dim` is 3'b010, `out_mask` has only bit `dst_y` set, and `out_wgrp` equals `self_y`.
- R4: A unicast addressed to the own tile selects local ejection. `out_dim` is 3'b100, and `out_mask`, `out_wgrp` and `out_wave_base` are all 0.
- R5: Whenever `out_valid` is high, `out_wave_base` equals `out_wgrp * LAMBDA_PER`, and the home channel at the sender's own position (`out_mask[out_wgrp]`) is never driven.
- R6: A row multicast (kind code 1) drives the row channel with every mask bit set except `self_x`, and `out_wgrp` = `self_x`. A column multicast (kind code 3) drives the column channel with every mask bit set except `self_y`, and `out_wgrp` = `self_y`. Multicasts have `out_step` 0 and `out_relay` 0.
- R7: A broadcast (kind code 2) yields exactly three output beats, with `out_step` 1, 2 and 3:
  - beat 1: a row multicast, `out_relay` 0;
  - beat 2: a column multicast, `out_relay` 0;
  - beat 3: a row multicast with `out_relay` 1.
- R8: `bcast_done` is high for exactly the one cycle after the handshake of broadcast step 3, and is never raised for any other kind.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all output fields hold their values.
- R10: `req_ready` is low while a decision is held without `out_ready`, and it stays low during broadcast steps 1 and 2 even with `out_ready` high. It rises when the final beat is taken, so a waiting request is accepted on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_id | input | 2*IDX_W | Index of this tile, captured with each request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when `req_valid` is also high |
| req_kind | input | 2 | 0 unicast, 1 row multicast, 2 broadcast, 3 column multicast |
| req_dest | input | 2*IDX_W | Destination tile index (used by unicast only) |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Consumer takes the decision |
| out_dim | output | 3 | One-hot: bit 0 row, bit 1 column, bit 2 local |
| out_mask | output | GRID | Destination home channels to drive |
| out_wgrp | output | IDX_W | Source wavelength group |
| out_wave_base | output | WAVE_W | First wavelength index of the group |
| out_relay | output | 1 | Receivers repeat this beat down their columns |
| out_step | output | 2 | Broadcast step 1..3, 0 otherwise |
| bcast_done | output | 1 | One-cycle pulse after the last broadcast beat |

## Verification
The bench builds the block with its defaults: `GRID` = 4 and `LAMBDA_PER` = 16. At that size all 16 x 16 source and destination pairs for unicast can be swept exhaustively, which covers the row, column and local cases and their stall behaviour.

Every tile is also run as the source of both multicast kinds and of a broadcast. In each broadcast a unicast request is kept waiting, so that the timing of `req_ready` and the `bcast_done` pulse are observed at the final-beat edge.

// File: rtl/otrs_pkg.sv
package otrs_pkg;
  typedef enum logic [1:0] {
    KIND_UNI   = 2'd0,
    KIND_ROWMC = 2'd1,
    KIND_BCAST = 2'd2,
    KIND_COLMC = 2'd3
  } req_kind_e;

  localparam int DIM_ROW   = 0;
  localparam int DIM_COL   = 1;
  localparam int DIM_LOCAL = 2;
  localparam int DIM_W     = 3;
endpackage

// File: rtl/otrs_onehot_mask.sv
module otrs_onehot_mask #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [IW-1:0] idx,
  input  logic          invert,
  output logic [N-1:0]  mask
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign mask[i] = (idx == IW'(i)) ^ invert;
  end
endmodule

// File: rtl/otrs_route_calc.sv
module otrs_route_calc
  import otrs_pkg::*;
#(
  parameter int GRID       = 4,
  parameter int LAMBDA_PER = 16,
  parameter int IDX_W      = $clog2(GRID),
  parameter int WAVE_W     = $clog2(GRID * LAMBDA_PER)
) (
  input  logic [IDX_W-1:0]  self_x,
  input  logic [IDX_W-1:0]  self_y,
  input  logic [IDX_W-1:0]  dst_x,
  input  logic [IDX_W-1:0]  dst_y,
  input  req_kind_e         kind,
  input  logic [1:0]        step,
  output logic [DIM_W-1:0]  dim,
  output logic [GRID-1:0]   mask,
  output logic [IDX_W-1:0]  wgrp,
  output logic [WAVE_W-1:0] wave_base,
  output logic              relay
);
  logic [IDX_W-1:0] sel_idx;
  logic             sel_inv;
  logic             is_local;
  logic [GRID-1:0]  raw_mask;

  // Dimension-ordered choice: the column is corrected first, then the row.
  always_comb begin
    dim      = '0;
    sel_idx  = '0;
    sel_inv  = 1'b0;
    wgrp     = '0;
    relay    = 1'b0;
    is_local = 1'b0;
    unique case (kind)
      KIND_UNI: begin
        if (dst_x != self_x) begin
          dim[DIM_ROW] = 1'b1;
          sel_idx      = dst_x;
          wgrp         = self_x;
        end else if (dst_y != self_y) begin
          dim[DIM_COL] = 1'b1;
          sel_idx      = dst_y;
          wgrp         = self_y;
        end else begin
          dim[DIM_LOCAL] = 1'b1;
          is_local       = 1'b1;
        end
      end
      KIND_ROWMC: begin
        dim[DIM_ROW] = 1'b1;
        sel_idx      = self_x;
        sel_inv      = 1'b1;
        wgrp         = self_x;
      end
      KIND_COLMC: begin
        dim[DIM_COL] = 1'b1;
        sel_idx      = self_y;
        sel_inv      = 1'b1;
        wgrp         = self_y;
      end
      KIND_BCAST: begin
        sel_inv = 1'b1;
        if (step == 2'd2) begin
          dim[DIM_COL] = 1'b1;
          sel_idx      = self_y;
          wgrp         = self_y;
        end else begin
          dim[DIM_ROW] = 1'b1;
          sel_idx      = self_x;
          wgrp         = self_x;
          relay        = (step == 2'd3);
        end
      end
      default: ;
    endcase
  end

  otrs_onehot_mask #(.N(GRID), .IW(IDX_W)) u_mask (
    .idx   (sel_idx),
    .invert(sel_inv),
    .mask  (raw_mask)
  );

  assign mask      = is_local ? '0 : raw_mask;
  assign wave_base = WAVE_W'(32'(wgrp) * LAMBDA_PER);
endmodule

// File: rtl/otrs_bcast_seq.sv
module otrs_bcast_seq
  import otrs_pkg::*;
#(
  parameter int TILE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  req_kind_e         req_kind,
  input  logic [TILE_W-1:0] req_dest,
  input  logic [TILE_W-1:0] req_self,
  output logic              req_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output req_kind_e         cur_kind,
  output logic [TILE_W-1:0] cur_dest,
  output logic [TILE_W-1:0] cur_self,
  output logic [1:0]        cur_step,
  output logic              done
);
  localparam logic [1:0] LAST_STEP = 2'd3;

  logic valid_q, done_q, last_beat;
  req_kind_e kind_q;
  logic [TILE_W-1:0] dest_q, self_q;
  logic [1:0] step_q;

  assign last_beat = (kind_q != KIND_BCAST) || (step_q == LAST_STEP);
  assign req_ready = !valid_q || (out_ready && last_beat);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      kind_q  <= KIND_UNI;
      dest_q  <= '0;
      self_q  <= '0;
      step_q  <= '0;
    end else begin
      done_q <= valid_q && out_ready && (kind_q == KIND_BCAST) && (step_q == LAST_STEP);
      if (req_valid && req_ready) begin
        valid_q <= 1'b1;
        kind_q  <= req_kind;
        dest_q  <= req_dest;
        self_q  <= req_self;
        step_q  <= (req_kind == KIND_BCAST) ? 2'd1 : 2'd0;
      end else if (valid_q && out_ready) begin
        if (last_beat) valid_q <= 1'b0;
        else           step_q  <= step_q + 2'd1;
      end
    end
  end

  assign out_valid = valid_q;
  assign cur_kind  = kind_q;
  assign cur_dest  = dest_q;
  assign cur_self  = self_q;
  assign cur_step  = step_q;
  assign done      = done_q;

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!valid_q && !done_q));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !out_ready) |=> (valid_q && $stable(kind_q) && $stable(step_q)
                                 && $stable(dest_q) && $stable(self_q)));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (valid_q && kind_q == KIND_BCAST && step_q != LAST_STEP) |-> !req_ready);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_step_range_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && kind_q == KIND_BCAST) |-> (step_q != 2'd0));
endmodule

// File: rtl/otrs_tile_route.sv
module otrs_tile_route
  import otrs_pkg::*;
#(
  parameter int GRID       = 4,
  parameter int LAMBDA_PER = 16,
  localparam int IDX_W     = $clog2(GRID),
  localparam int TILE_W    = 2 * IDX_W,
  localparam int WAVE_W    = $clog2(GRID * LAMBDA_PER)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TILE_W-1:0] self_id,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [TILE_W-1:0] req_dest,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_dim,
  output logic [GRID-1:0]   out_mask,
  output logic [IDX_W-1:0]  out_wgrp,
  output logic [WAVE_W-1:0] out_wave_base,
  output logic              out_relay,
  output logic [1:0]        out_step,
  output logic              bcast_done
);
  req_kind_e         cur_kind;
  logic [TILE_W-1:0] cur_dest, cur_self;

  otrs_bcast_seq #(.TILE_W(TILE_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_kind (req_kind_e'(req_kind)),
    .req_dest (req_dest),
    .req_self (self_id),
    .req_ready(req_ready),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .cur_kind (cur_kind),
    .cur_dest (cur_dest),
    .cur_self (cur_self),
    .cur_step (out_step),
    .done     (bcast_done)
  );

  otrs_route_calc #(.GRID(GRID), .LAMBDA_PER(LAMBDA_PER)) u_calc (
    .self_x   (cur_self[IDX_W-1:0]),
    .self_y   (cur_self[TILE_W-1:IDX_W]),
    .dst_x    (cur_dest[IDX_W-1:0]),
    .dst_y    (cur_dest[TILE_W-1:IDX_W]),
    .kind     (cur_kind),
    .step     (out_step),
    .dim      (out_dim),
    .mask     (out_mask),
    .wgrp     (out_wgrp),
    .wave_base(out_wave_base),
    .relay    (out_relay)
  );

  assert_dim_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_dim) == 1));

  assert_diag_empty_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_mask[out_wgrp]);

  assert_local_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dim[DIM_LOCAL]) |-> (out_mask == '0 && out_wave_base == '0));

  assert_relay_last_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_relay) |-> (out_step == 2'd3 && out_dim[DIM_ROW]));
endmodule

// File: tb/otrs_tile_route_test.sv
`timescale 1ns/1ps
module otrs_tile_route_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] self_id, req_dest;
  logic       req_valid, req_ready, out_valid, out_ready;
  logic [1:0] req_kind, out_wgrp, out_step;
  logic [2:0] out_dim;
  logic [3:0] out_mask;
  logic [5:0] out_wave_base;
  logic       out_relay, bcast_done;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  otrs_tile_route uut (
    .clk(clk), .rst(rst), .self_id(self_id), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_dest(req_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_dim(out_dim),
    .out_mask(out_mask), .out_wgrp(out_wgrp), .out_wave_base(out_wave_base),
    .out_relay(out_relay), .out_step(out_step), .bcast_done(bcast_done)
  );

  task automatic check(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_beat(string tag, int edim, int emask, int ewg, int erelay, int estep);
    check(tag, "out_valid", int'(out_valid), 1);
    check(tag, "out_dim", int'(out_dim), edim);
    check(tag, "out_mask", int'(out_mask), emask);
    check(tag, "out_wgrp", int'(out_wgrp), ewg);
    check("R5", "out_wave_base", int'(out_wave_base), ewg * 16);
    check(tag, "out_relay", int'(out_relay), erelay);
    check(tag, "out_step", int'(out_step), estep);
  endtask

  task automatic run_unicast(int s, int d);
    int sx = s % 4, sy = s / 4, dx = d % 4, dy = d / 4;
    int edim, emask, ewg;
    string tag;
    if (dx != sx)      begin edim = 1; emask = 1 << dx; ewg = sx; tag = "R2"; end
    else if (dy != sy) begin edim = 2; emask = 1 << dy; ewg = sy; tag = "R3"; end
    else               begin edim = 4; emask = 0;       ewg = 0;  tag = "R4"; end
    @(negedge clk);
    self_id = 4'(s); req_dest = 4'(d); req_kind = 2'd0; req_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check_beat(tag, edim, emask, ewg, 0, 0);
    check("R10", "req_ready while held", int'(req_ready), 0);
    @(negedge clk);
    check_beat("R9", edim, emask, ewg, 0, 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R9", "out_valid after take", int'(out_valid), 0);
  endtask

  task automatic run_multicast(int s, int kind);
    int sx = s % 4, sy = s / 4;
    @(negedge clk);
    self_id = 4'(s); req_dest = 4'(15 - s); req_kind = 2'(kind); req_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (kind == 1) check_beat("R6", 1, (~(1 << sx)) & 15, sx, 0, 0);
    else           check_beat("R6", 2, (~(1 << sy)) & 15, sy, 0, 0);
    @(negedge clk);
    out_ready = 1'b0;
    check("R6", "out_valid after multicast", int'(out_valid), 0);
    check("R8", "no done for multicast", int'(bcast_done), 0);
  endtask

  task automatic run_broadcast(int s);
    int sx = s % 4, sy = s / 4;
    int wd = s ^ 1;
    @(negedge clk);
    self_id = 4'(s); req_dest = 4'(s); req_kind = 2'd2; req_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check_beat("R7", 1, (~(1 << sx)) & 15, sx, 0, 1);
    req_kind = 2'd0; req_dest = 4'(wd);
    check("R10", "req_ready step1 stalled", int'(req_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    check_beat("R7", 2, (~(1 << sy)) & 15, sy, 0, 2);
    check("R10", "req_ready step2", int'(req_ready), 0);
    check("R8", "done early", int'(bcast_done), 0);
    @(negedge clk);
    check_beat("R7", 1, (~(1 << sx)) & 15, sx, 1, 3);
    check("R10", "req_ready final beat", int'(req_ready), 1);
    check("R8", "done early", int'(bcast_done), 0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8", "done pulse", int'(bcast_done), 1);
    check_beat("R10", 1, 1 << (wd % 4), sx, 0, 0);
    @(negedge clk);
    out_ready = 1'b0;
    check("R8", "done single cycle", int'(bcast_done), 0);
    check("R10", "queue drained", int'(out_valid), 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; out_ready = 1'b0;
    self_id = '0; req_dest = '0; req_kind = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "bcast_done after reset", int'(bcast_done), 0);
    check("R1", "req_ready after reset", int'(req_ready), 1);
    for (int s = 0; s < 16; s++)
      for (int d = 0; d < 16; d++)
        run_unicast(s, d);
    for (int s = 0; s < 16; s++) begin
      run_multicast(s, 1);
      run_multicast(s, 3);
    end
    for (int s = 0; s < 16; s++)
      run_broadcast(s);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule